// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the protocol layer of a 256-byte serial memory slave. A bit-level engine below it recovers whole bytes and single acknowledge bits from the line. This block sees the start of a transfer, checks who is addressed, decodes the opcode and collects a word address. It streams stored bytes or the status byte back, and it gathers up to sixteen incoming bytes in a page latch. For every byte it also chooses the slave acknowledge value, and after a fault it falls into an idle state that only a standby pulse ends.

Writes are not instant. An end-of-operation bit starts a timed write cycle. A clock-count timer stands in for the nonvolatile programming time. During the first cycles of that window the block sweeps the page latch, or the whole array for the two fill commands, into its internal 256x8 storage. For page writes it asks a neighbouring protection block, one address at a time, whether that address may be written. The block protect bits live in that neighbour, and a status write hands the new value across through a one-cycle strobe.

Top module: `eeprom_seq`

## Requirements
- R1: The first byte after a header must be 0xA0. On a match, a continue bit is answered with acknowledge 1 and leads to command decode, and an end bit is answered with acknowledge 1 and returns to standby. On any other value the slave answers 0 and goes idle.
- R2: The accepted opcodes are 0x03, 0x06, 0x6C, 0x96, 0x91, 0x05, 0x6E, 0x6D and 0x67. Any other opcode is answered with acknowledge 0 and sends the slave idle.
- R3: Opcode 0x03 takes a high and a low address byte, loads the pointer from the low byte, and returns the byte at the pointer. Each master acknowledge after a data byte advances the pointer by one, wrapping from 0xFF to 0x00.
- R4: Opcode 0x06 returns data from the current pointer, which is left one past the last byte acknowledged in the previous read.
- R5: Opcode 0x6C buffers data bytes at the pointer, and only the low four pointer bits advance. Bytes past the end of a 16-byte page therefore wrap to the start of the same page.
- R6: A write cycle starts only on an end bit after at least one data byte while the write enable is set. An end bit straight after the address bytes gives acknowledge 0 and idle. A standby pulse in place of the end bit writes nothing.
- R7: Opcodes 0x96, 0x91, 0x6D and 0x67 need an end bit directly after the opcode. A continue bit there gives acknowledge 0, idle and no effect.
- R8: While a write cycle runs, opcodes 0x03, 0x06, 0x6C, 0x6E, 0x6D and 0x67 are answered with 0 and send the slave idle. Opcode 0x05 still works.
- R9: The status byte is {4'b0000, protect[1:0], writeEnable, writeInProgress} and may be polled repeatedly with continue bits. The write enable is cleared by 0x91 and when a page write, status write or fill is started.
- R10: Opcode 0x6D fills the array with 0x00, and 0x67 fills it with 0xFF. A fill runs only when the write enable is set and protect is 00; otherwise the command has no effect.
- R11: In idle the slave ignores headers, bytes and acknowledge bits until a standby pulse. After a valid end bit it accepts a new header without a standby pulse.
- R12: During a page write, a buffered byte is stored only if protOk is high for its address.
- R13: Opcode 0x6E followed by a data byte and an end bit pulses statusWe once with data bits [3:2] on statusNew, provided the write enable is set. A continue bit in that position gives acknowledge 0 and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hdrDone | input | 1 | Start header and its acknowledge completed |
| rxValid | input | 1 | A byte from the master is complete |
| rxByte | input | 8 | Received byte |
| mAckValid | input | 1 | Master acknowledge bit received |
| mAckBit | input | 1 | 1 = continue, 0 = end |
| standby | input | 1 | Standby pulse detected |
| txByte | output | 8 | Byte to transmit in read and status phases |
| sakValid | output | 1 | Slave acknowledge decision ready (one cycle) |
| sakBit | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| idleMode | output | 1 | Slave is idle |
| protLevel | input | 2 | Block protect bits from the protection block |
| protAddr | output | 8 | Address queried for write permission |
| protOk | input | 1 | Queried address may be written |
| statusWe | output | 1 | Status write strobe |
| statusNew | output | 2 | New block protect bits |

## Verification
A status read and a running write cycle can share the same cycles. The status byte is built from the live write-in-progress flag while the fill sweep writes the array and the timer counts. The bench starts a fill and issues a status read at once, then polls it. It expects write-in-progress set and write enable already clear. Right after that it sends a read command, which must be refused while the cycle runs, and it checks the filled contents only after the timer has expired.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [3:0] {
    ST_STANDBY, ST_IDLE, ST_DEVADDR, ST_CMD, ST_ADDRH, ST_ADDRL,
    ST_RDATA, ST_WDATA, ST_SREAD, ST_SWRITE
  } seqState_t;

  typedef enum logic [1:0] {WK_PAGE, WK_FILL0, WK_FILL1, WK_STAT} wrKind_t;

  localparam logic [7:0] DEV_ID    = 8'hA0;
  localparam logic [7:0] OP_RDADDR = 8'h03;
  localparam logic [7:0] OP_RDCUR  = 8'h06;
  localparam logic [7:0] OP_WRPAGE = 8'h6C;
  localparam logic [7:0] OP_WEN    = 8'h96;
  localparam logic [7:0] OP_WDIS   = 8'h91;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WRSTAT = 8'h6E;
  localparam logic [7:0] OP_FILL0  = 8'h6D;
  localparam logic [7:0] OP_FILL1  = 8'h67;

  typedef struct packed {
    logic    loadPtr;
    logic    incPtr;
    logic    incPage;
    logic    latchByte;
    logic    clearLatch;
    logic    startWr;
    wrKind_t kind;
    logic    selStatus;
  } seqStrb_t;
endpackage

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hdrDone,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       mAckValid,
  input  logic       mAckBit,
  input  logic       standby,
  input  logic       busy,
  input  logic [1:0] protLevel,
  output seqStrb_t   strb,
  output logic       wel,
  output logic       sakValid,
  output logic       sakBit,
  output logic       idleMode
);
  seqState_t state, nextState;
  logic [7:0] opReg;
  logic devOk, sakNow, welSet, welClr, validOp, writeClass;

  always_comb begin
    validOp = opReg inside {OP_RDADDR, OP_RDCUR, OP_WRPAGE, OP_WEN, OP_WDIS,
                            OP_RDSTAT, OP_WRSTAT, OP_FILL0, OP_FILL1};
    writeClass = opReg inside {OP_RDADDR, OP_RDCUR, OP_WRPAGE, OP_WRSTAT,
                               OP_FILL0, OP_FILL1};
  end

  always_comb begin
    nextState = state;
    strb = '0;
    sakNow = 1'b0;
    welSet = 1'b0;
    welClr = 1'b0;
    case (state)
      ST_STANDBY: if (hdrDone) nextState = ST_DEVADDR;
      ST_DEVADDR: if (mAckValid) begin
        if (!devOk) nextState = ST_IDLE;
        else begin
          sakNow = 1'b1;
          nextState = mAckBit ? ST_CMD : ST_STANDBY;
        end
      end
      ST_CMD: if (mAckValid) begin
        nextState = ST_IDLE;
        if (validOp && !(busy && writeClass)) begin
          case (opReg)
            OP_RDADDR, OP_WRPAGE: if (mAckBit) begin sakNow = 1'b1; nextState = ST_ADDRH; end
            OP_RDCUR:  if (mAckBit) begin sakNow = 1'b1; nextState = ST_RDATA; end
            OP_RDSTAT: if (mAckBit) begin sakNow = 1'b1; nextState = ST_SREAD; end
            OP_WRSTAT: if (mAckBit) begin sakNow = 1'b1; nextState = ST_SWRITE; end
            default: if (!mAckBit) begin
              sakNow = 1'b1;
              nextState = ST_STANDBY;
              if (opReg == OP_WEN) welSet = 1'b1;
              else if (opReg == OP_WDIS) welClr = 1'b1;
              else if (wel && protLevel == 2'b00) begin
                strb.startWr = 1'b1;
                strb.kind = (opReg == OP_FILL0) ? WK_FILL0 : WK_FILL1;
                welClr = 1'b1;
              end
            end
          endcase
        end
      end
      ST_ADDRH: if (mAckValid) begin
        nextState = mAckBit ? ST_ADDRL : ST_IDLE;
        sakNow = mAckBit;
      end
      ST_ADDRL: if (mAckValid) begin
        nextState = ST_IDLE;
        if (mAckBit) begin
          sakNow = 1'b1;
          strb.loadPtr = 1'b1;
          strb.clearLatch = 1'b1;
          nextState = (opReg == OP_WRPAGE) ? ST_WDATA : ST_RDATA;
        end
      end
      ST_RDATA: if (mAckValid) begin
        sakNow = 1'b1;
        strb.incPtr = 1'b1;
        nextState = mAckBit ? ST_RDATA : ST_STANDBY;
      end
      ST_WDATA: begin
        strb.latchByte = rxValid;
        if (mAckValid) begin
          sakNow = 1'b1;
          strb.incPage = 1'b1;
          if (!mAckBit) begin
            nextState = ST_STANDBY;
            if (wel) begin strb.startWr = 1'b1; strb.kind = WK_PAGE; welClr = 1'b1; end
          end
        end
      end
      ST_SREAD: begin
        strb.selStatus = 1'b1;
        if (mAckValid) begin
          sakNow = 1'b1;
          nextState = mAckBit ? ST_SREAD : ST_STANDBY;
        end
      end
      ST_SWRITE: if (mAckValid) begin
        nextState = ST_IDLE;
        if (!mAckBit) begin
          sakNow = 1'b1;
          nextState = ST_STANDBY;
          if (wel) begin strb.startWr = 1'b1; strb.kind = WK_STAT; welClr = 1'b1; end
        end
      end
      default: ;
    endcase
    if (standby) begin
      nextState = ST_STANDBY;
      strb = '0;
      welSet = 1'b0;
      welClr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_STANDBY;
      opReg <= '0;
      devOk <= 1'b0;
      wel <= 1'b0;
      sakValid <= 1'b0;
      sakBit <= 1'b0;
    end else begin
      state <= nextState;
      if (rxValid && state == ST_DEVADDR) devOk <= (rxByte == DEV_ID);
      if (rxValid && state == ST_CMD) opReg <= rxByte;
      if (welSet) wel <= 1'b1;
      else if (welClr) wel <= 1'b0;
      sakValid <= mAckValid && !standby && state != ST_STANDBY && state != ST_IDLE;
      sakBit <= sakNow;
    end
  end

  assign idleMode = (state == ST_IDLE);
endmodule

// File: rtl/eeprom_seq_dp.sv
module eeprom_seq_dp
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              wel,
  input  logic [1:0]        protLevel,
  input  logic              protOk,
  output logic [ADDR_W-1:0] protAddr,
  output logic [7:0]        txByte,
  output logic              busy,
  output logic              statusWe,
  output logic [1:0]        statusNew
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [7:0] mem [DEPTH];
  logic [7:0] pageLat [PAGE];
  logic [PAGE-1:0] pageMask;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-PAGE_W-1:0] wrPage;
  logic [7:0] rxHold;
  logic [TW-1:0] timer;
  wrKind_t kind;
  logic [1:0] statNew;
  logic [ADDR_W-1:0] sweepIdx;
  logic [PAGE_W-1:0] lowIdx;

  assign sweepIdx = timer[ADDR_W-1:0];
  assign lowIdx = sweepIdx[PAGE_W-1:0];
  assign protAddr = (kind == WK_PAGE) ? {wrPage, lowIdx} : sweepIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      rxHold <= '0;
      pageMask <= '0;
      busy <= 1'b0;
      timer <= '0;
      kind <= WK_PAGE;
      wrPage <= '0;
      statNew <= '0;
    end else begin
      if (rxValid) rxHold <= rxByte;
      if (strb.loadPtr) ptr <= rxHold[ADDR_W-1:0];
      else if (strb.incPtr) ptr <= ptr + 1'b1;
      else if (strb.incPage) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      if (strb.clearLatch) pageMask <= '0;
      else if (strb.latchByte) pageMask[ptr[PAGE_W-1:0]] <= 1'b1;
      if (strb.startWr) begin
        busy <= 1'b1;
        timer <= '0;
        kind <= strb.kind;
        wrPage <= ptr[ADDR_W-1:PAGE_W];
        statNew <= rxHold[3:2];
      end else if (busy) begin
        if (timer == TW'(WR_CYCLES - 1)) busy <= 1'b0;
        else timer <= timer + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.latchByte) pageLat[ptr[PAGE_W-1:0]] <= rxByte;
    if (busy && timer < TW'(DEPTH)) begin
      case (kind)
        WK_FILL0: mem[sweepIdx] <= 8'h00;
        WK_FILL1: mem[sweepIdx] <= 8'hFF;
        WK_PAGE:  if (timer < TW'(PAGE) && pageMask[lowIdx] && protOk)
                    mem[protAddr] <= pageLat[lowIdx];
        default: ;
      endcase
    end
  end

  assign statusWe = busy && kind == WK_STAT && timer == '0;
  assign statusNew = statNew;
  assign txByte = strb.selStatus ? {4'b0000, protLevel, wel, busy} : mem[ptr];
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int WR_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hdrDone,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       mAckValid,
  input  logic       mAckBit,
  input  logic       standby,
  output logic [7:0] txByte,
  output logic       sakValid,
  output logic       sakBit,
  output logic       idleMode,
  input  logic [1:0] protLevel,
  output logic [7:0] protAddr,
  input  logic       protOk,
  output logic       statusWe,
  output logic [1:0] statusNew
);
  seqStrb_t strb;
  logic wel, busy, startWr;
  assign startWr = strb.startWr;

  eeprom_seq_ctrl u_ctrl (
    .clk, .rstN, .hdrDone, .rxValid, .rxByte, .mAckValid, .mAckBit,
    .standby, .busy, .protLevel, .strb, .wel, .sakValid, .sakBit, .idleMode
  );

  eeprom_seq_dp #(.ADDR_W(8), .PAGE_W(4), .WR_CYCLES(WR_CYCLES)) u_dp (
    .clk, .rstN, .strb, .rxValid, .rxByte, .wel, .protLevel, .protOk,
    .protAddr, .txByte, .busy, .statusWe, .statusNew
  );
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk (
  input logic clk,
  input logic rstN,
  input logic mAckValid,
  input logic sakValid,
  input logic sakBit,
  input logic idleMode,
  input logic standby,
  input logic startWr,
  input logic busy
);
  p_sak_follows_ack_r1: assert property (@(posedge clk) disable iff (!rstN)
    sakValid |-> $past(mAckValid));
  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (idleMode && !standby) |=> idleMode);
  p_nosak_on_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleMode) |-> (sakValid && !sakBit));
  p_start_when_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    startWr |-> !busy);
  p_busy_from_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startWr));
endmodule

bind eeprom_seq eeprom_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .mAckValid(mAckValid), .sakValid(sakValid),
  .sakBit(sakBit), .idleMode(idleMode), .standby(standby),
  .startWr(startWr), .busy(busy)
);

// File: tb/test_eeprom_seq.sv
`timescale 1ns/1ps
module test_eeprom_seq;
  localparam int WRC = 300;
  localparam logic [15:0] VEC [0:6] = '{16'h1DFF, 16'h1E11, 16'h1F22,
                                        16'h1033, 16'h11FF, 16'h20FF, 16'h0FFF};

  logic clk = 0, rstN = 0;
  logic hdrDone = 0, rxValid = 0, mAckValid = 0, mAckBit = 0, standby = 0;
  logic [7:0] rxByte = 0;
  logic [7:0] txByte, protAddr;
  logic sakValid, sakBit, idleMode, statusWe, protOk;
  logic [1:0] statusNew;
  logic [1:0] protLevel = 2'b00;
  int nChecks = 0, nFail = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  eeprom_seq #(.WR_CYCLES(WRC)) i_eeprom_seq (
    .clk, .rstN, .hdrDone, .rxValid, .rxByte, .mAckValid, .mAckBit, .standby,
    .txByte, .sakValid, .sakBit, .idleMode, .protLevel, .protAddr, .protOk,
    .statusWe, .statusNew
  );

  // neighbouring protection block model
  always_comb
    case (protLevel)
      2'b00: protOk = 1'b1;
      2'b01: protOk = protAddr < 8'hC0;
      2'b10: protOk = protAddr < 8'h80;
      default: protOk = 1'b0;
    endcase
  always @(posedge clk) if (statusWe) protLevel <= statusNew;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulseHdr();
    @(negedge clk) hdrDone = 1;
    @(negedge clk) hdrDone = 0;
  endtask

  task automatic sendB(logic [7:0] b);
    @(negedge clk) begin rxValid = 1; rxByte = b; end
    @(negedge clk) rxValid = 0;
  endtask

  // exp: 3 = acknowledge, 2 = no acknowledge, 0 = no response
  task automatic ackB(logic b, logic [7:0] exp, string tag);
    @(negedge clk) begin mAckValid = 1; mAckBit = b; end
    @(negedge clk) mAckValid = 0;
    chk(tag, {6'b0, sakValid, sakBit}, exp);
  endtask

  task automatic stby();
    @(negedge clk) standby = 1;
    @(negedge clk) standby = 0;
  endtask

  task automatic startCmd(logic [7:0] op, string tag);
    pulseHdr();
    sendB(8'hA0);
    ackB(1, 3, tag);
    sendB(op);
  endtask

  task automatic waitWr();
    repeat (WRC + 10) @(negedge clk);
  endtask

  task automatic simpleCmd(logic [7:0] op, string tag);
    startCmd(op, tag);
    ackB(0, 3, tag);
  endtask

  task automatic readOne(logic [7:0] a, output logic [7:0] d);
    startCmd(8'h03, "R3");
    ackB(1, 3, "R3");
    sendB(8'h00); ackB(1, 3, "R3");
    sendB(a);     ackB(1, 3, "R3");
    d = txByte;
    ackB(0, 3, "R3");
  endtask

  task automatic writeBytes(logic [7:0] a, logic [7:0] b0, int n, string tag);
    startCmd(8'h6C, tag);
    ackB(1, 3, tag);
    sendB(8'h00); ackB(1, 3, tag);
    sendB(a);     ackB(1, 3, tag);
    for (int i = 0; i < n; i++) begin
      sendB(b0 + 8'(i * 8'h11));
      ackB(i == n - 1 ? 1'b0 : 1'b1, 3, tag);
    end
  endtask

  task automatic readStatus(logic [7:0] exp, string tag);
    startCmd(8'h05, tag);
    ackB(1, 3, tag);
    chk(tag, txByte, exp);
    ackB(0, 3, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("RST idle", {7'b0, idleMode}, 0);
    chk("RST sak", {7'b0, sakValid}, 0);
    rstN = 1;
    @(negedge clk);

    // R7/R9: enable, then status polled twice
    simpleCmd(8'h96, "R7");
    startCmd(8'h05, "R9");
    ackB(1, 3, "R9");
    chk("R9 status", txByte, 8'h02);
    ackB(1, 3, "R9");
    chk("R9 poll", txByte, 8'h02);
    ackB(0, 3, "R9");

    // R10/R8: fill 0xFF, status during cycle, read refused
    simpleCmd(8'h67, "R10");
    readStatus(8'h01, "R8");
    startCmd(8'h03, "R8");
    ackB(1, 2, "R8");
    chk("R8 idle", {7'b0, idleMode}, 1);
    stby();
    waitWr();

    // R5: page wrap write 0x1E,0x1F,0x10
    simpleCmd(8'h96, "R5");
    writeBytes(8'h1E, 8'h11, 3, "R5");
    waitWr();
    simpleCmd(8'h96, "R3");
    startCmd(8'h6C, "R3"); ackB(1, 3, "R3");
    sendB(8'h00); ackB(1, 3, "R3");
    sendB(8'h00); ackB(1, 3, "R3");
    sendB(8'hA5); ackB(1, 3, "R3");
    sendB(8'h5A); ackB(0, 3, "R3");
    waitWr();

    for (int k = 0; k < 7; k++) begin
      readOne(VEC[k][15:8], rd);
      chk("R5 readback", rd, VEC[k][7:0]);
    end

    // R3 wrap 0xFF->0x00, R4 current read
    startCmd(8'h03, "R3"); ackB(1, 3, "R3");
    sendB(8'h00); ackB(1, 3, "R3");
    sendB(8'hFF); ackB(1, 3, "R3");
    chk("R3 top", txByte, 8'hFF);
    ackB(1, 3, "R3");
    chk("R3 wrap", txByte, 8'hA5);
    ackB(0, 3, "R3");
    startCmd(8'h06, "R4"); ackB(1, 3, "R4");
    chk("R4 current", txByte, 8'h5A);
    ackB(0, 3, "R4");

    // R6: standby replaces end bit; end bit with no data
    simpleCmd(8'h96, "R6");
    startCmd(8'h6C, "R6"); ackB(1, 3, "R6");
    sendB(8'h00); ackB(1, 3, "R6");
    sendB(8'h40); ackB(1, 3, "R6");
    sendB(8'h77);
    stby();
    readStatus(8'h02, "R6");
    readOne(8'h40, rd);
    chk("R6 aborted", rd, 8'hFF);
    startCmd(8'h6C, "R6"); ackB(1, 3, "R6");
    sendB(8'h00); ackB(1, 3, "R6");
    sendB(8'h41); ackB(0, 2, "R6");
    chk("R6 idle", {7'b0, idleMode}, 1);
    stby();

    // R9/R6: disable, write has no effect
    simpleCmd(8'h91, "R9");
    writeBytes(8'h50, 8'h66, 1, "R6");
    readStatus(8'h00, "R9");
    readOne(8'h50, rd);
    chk("R6 no wel", rd, 8'hFF);

    // R7/R11: continue after enable, idle ignores traffic
    startCmd(8'h96, "R7");
    ackB(1, 2, "R7");
    pulseHdr(); sendB(8'hA0);
    ackB(1, 0, "R11");
    chk("R11 idle", {7'b0, idleMode}, 1);
    stby();
    readStatus(8'h00, "R7");

    // R1: wrong address, end bit after address, R11 back-to-back
    pulseHdr(); sendB(8'hA1);
    ackB(1, 2, "R1");
    chk("R1 idle", {7'b0, idleMode}, 1);
    stby();
    pulseHdr(); sendB(8'hA0);
    ackB(0, 3, "R1");
    readStatus(8'h00, "R11");

    // R2: unknown opcode
    startCmd(8'h55, "R2");
    ackB(1, 2, "R2");
    chk("R2 idle", {7'b0, idleMode}, 1);
    stby();

    // R13: status write to 01
    simpleCmd(8'h96, "R13");
    startCmd(8'h6E, "R13"); ackB(1, 3, "R13");
    sendB(8'h04); ackB(0, 3, "R13");
    waitWr();
    readStatus(8'h04, "R13");

    // R10: fill ignored under protection
    simpleCmd(8'h96, "R10");
    simpleCmd(8'h6D, "R10");
    waitWr();
    readOne(8'h00, rd);
    chk("R10 protected fill", rd, 8'hA5);

    // R12: write into protected quarter
    simpleCmd(8'h96, "R12");
    writeBytes(8'hC2, 8'h12, 1, "R12");
    waitWr();
    readOne(8'hC2, rd);
    chk("R12 protected", rd, 8'hFF);

    // R13 continue bit
    simpleCmd(8'h96, "R13");
    startCmd(8'h6E, "R13"); ackB(1, 3, "R13");
    sendB(8'h00); ackB(1, 2, "R13");
    chk("R13 idle", {7'b0, idleMode}, 1);
    stby();

    // R10: clear protection, fill 0x00
    startCmd(8'h6E, "R10"); ackB(1, 3, "R10");
    sendB(8'h00); ackB(0, 3, "R10");
    waitWr();
    simpleCmd(8'h96, "R10");
    simpleCmd(8'h6D, "R10");
    waitWr();
    readOne(8'h1E, rd);
    chk("R10 fill zero", rd, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule